// File: doc/BRIEF.md
# Priority-Tagged Set Access Controller

This block guards the sets of a set-associative cache that is partitioned at set granularity. Every set carries a priority level taken from the same range as task priorities, together with the identifier of the task that last claimed it. On each access the block receives a set index, the requesting task's priority and the task's identifier. It decides in the same cycle whether that task may use the set. A task may use a set only when its own priority is at least the set's current level. A granted access lifts the set to the task's level and records the task as owner.

When a task finishes, a completion pulse starts a sweep that walks every set, one per clock cycle. The sweep returns to the lowest level each set whose recorded owner is the finishing task. While the sweep runs, a busy output is high and access requests are neither granted nor denied. Tag matching, way choice and the data array belong to the surrounding cache and are not part of this block.

Top module: `set_prio_guard`

## Requirements
- R1: After reset every set's priority is 0 (the lowest level; 7 is the highest, compared as unsigned 3-bit values) and `busy` is low.
- R2: With `reqValid` high and `busy` low, `grant` is high in the same cycle when `reqPrio` is greater than or equal to the stored priority of set `reqSet`, and `deny` is high otherwise. `grant` and `deny` are never high together, and both are low when `reqValid` is low.
- R3: A granted access sets the stored priority of set `reqSet` to `reqPrio` from the next cycle on, and records `reqTask` as that set's owner.
- R4: A denied access leaves the set's priority and owner unchanged.
- R5: A granted access by a task whose priority equals the set's current level, while the set has a different owner, keeps the level and passes ownership to the new task. After that, completion of the old owner no longer releases the set, and completion of the new owner does.
- R6: `setPrio` always shows the stored priority of the set selected by `reqSet`, whether or not `reqValid` is high, as it was before any update made by the current cycle's access.
- R7: A `doneValid` pulse sampled while `busy` is low starts a sweep. `busy` is high for exactly NUM_SETS cycles, starting in the cycle after the pulse. At its end, every set whose owner equals `doneTask` is at priority 0, and every other set keeps its priority.
- R8: While `busy` is high, an access request produces neither `grant` nor `deny` and changes no set.
- R9: A `doneValid` pulse that arrives while `busy` is high is ignored. Sets owned by the task it names keep their priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqSet | input | 6 | Index of the set being accessed or observed |
| reqPrio | input | 3 | Priority of the requesting task (0 lowest, 7 highest) |
| reqTask | input | 4 | Identifier of the requesting task |
| doneValid | input | 1 | Completion pulse for the task named on doneTask |
| doneTask | input | 4 | Identifier of the task that finished |
| grant | output | 1 | Access allowed; set is claimed at the next edge |
| deny | output | 1 | Access refused; nothing changes |
| setPrio | output | 3 | Current stored priority of set reqSet |
| busy | output | 1 | Release sweep in progress; requests are stalled |

## Verification
Accesses are tried with the task priority above, equal to and below the set's level. This separates a correct at-least comparison from a strict one and from a reversed one. The equal-level case is tried once with the same owner and once with a different owner, and a later completion shows which task the set remembers. Completions are issued for tasks that own sets scattered across the index range, including the first and last index, and for a task that owns only a set claimed by someone else since. This shows that the sweep clears by owner and not by level. A request and a second completion are injected during a sweep to show that both are stalled or dropped.

// File: rtl/spg_pkg.sv
package spg_pkg;

  // Sweep controller state
  typedef enum logic {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } sweep_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic claim;      // write reqPrio/reqTask into the requested set
    logic sweepStep;  // examine one set for release this cycle
  } spg_strobe_t;

endpackage

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int PRIO_W   = 3,
  parameter int TASK_W   = 4,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spg_strobe_t       strobe,
  input  logic [SET_W-1:0]  reqSet,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [TASK_W-1:0] reqTask,
  input  logic [SET_W-1:0]  sweepIdx,
  input  logic [TASK_W-1:0] sweepTask,
  output logic [PRIO_W-1:0] setPrio,
  output logic              accessOk
);

  localparam int PRIO_BITS = NUM_SETS * PRIO_W;
  localparam int TASK_BITS = NUM_SETS * TASK_W;

  logic [PRIO_BITS-1:0] prioFlat;
  logic [TASK_BITS-1:0] ownerFlat;
  logic                 sweepHit;

  // Per-set storage: level and owner
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic selAccess;
    logic selSweep;

    assign selAccess = strobe.claim && (reqSet == SET_W'(s));
    assign selSweep  = strobe.sweepStep && (sweepIdx == SET_W'(s)) && sweepHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioFlat[s*PRIO_W +: PRIO_W]  <= '0;
        ownerFlat[s*TASK_W +: TASK_W] <= '0;
      end else if (selAccess) begin
        prioFlat[s*PRIO_W +: PRIO_W]  <= reqPrio;
        ownerFlat[s*TASK_W +: TASK_W] <= reqTask;
      end else if (selSweep) begin
        prioFlat[s*PRIO_W +: PRIO_W]  <= '0;
      end
    end
  end

  // Read side: level of the addressed set and the owner under the sweep
  assign setPrio  = prioFlat[reqSet*PRIO_W +: PRIO_W];
  assign accessOk = (reqPrio >= setPrio);
  assign sweepHit = (ownerFlat[sweepIdx*TASK_W +: TASK_W] == sweepTask);

  // Capture of the last claim, used only by the checks below
  logic              claimQ;
  logic [SET_W-1:0]  claimSetQ;
  logic [PRIO_W-1:0] claimPrioQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claimQ     <= 1'b0;
      claimSetQ  <= '0;
      claimPrioQ <= '0;
    end else begin
      claimQ     <= strobe.claim;
      claimSetQ  <= reqSet;
      claimPrioQ <= reqPrio;
    end
  end

  // R3
  claim_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    claimQ |-> prioFlat[claimSetQ*PRIO_W +: PRIO_W] == claimPrioQ);

  // R4 R8
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.claim && !strobe.sweepStep) |=> ($stable(prioFlat) && $stable(ownerFlat)));

  // R7
  sweep_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sweepStep && !sweepHit) |=> $stable(prioFlat));

  // R7
  sweep_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sweepStep |=> $stable(ownerFlat));

endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int TASK_W   = 4,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam logic [SET_W-1:0] LAST_IDX = SET_W'(NUM_SETS - 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              doneValid,
  input  logic [TASK_W-1:0] doneTask,
  input  logic              accessOk,
  output logic              grant,
  output logic              deny,
  output logic              busy,
  output spg_strobe_t       strobe,
  output logic [SET_W-1:0]  sweepIdx,
  output logic [TASK_W-1:0] sweepTask
);

  sweep_state_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SWP_IDLE;
      sweepIdx  <= '0;
      sweepTask <= '0;
    end else begin
      unique case (state)
        SWP_IDLE: begin
          if (doneValid) begin
            state     <= SWP_RUN;
            sweepIdx  <= '0;
            sweepTask <= doneTask;
          end
        end
        SWP_RUN: begin
          if (sweepIdx == LAST_IDX) begin
            state    <= SWP_IDLE;
            sweepIdx <= '0;
          end else begin
            sweepIdx <= sweepIdx + 1'b1;
          end
        end
        default: state <= SWP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy             = (state == SWP_RUN);
    grant            = reqValid && !busy && accessOk;
    deny             = reqValid && !busy && !accessOk;
    strobe.claim     = grant;
    strobe.sweepStep = busy;
  end

  // R2
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && deny));

  // R7
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && doneValid) |=> (busy && sweepIdx == '0));

  // R7
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (sweepIdx == $past(sweepIdx) + 1'b1));

  // R7
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sweepIdx == LAST_IDX) |=> !busy);

  // R9
  done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && doneValid) |=> $stable(sweepTask));

endmodule

// File: rtl/set_prio_guard.sv
module set_prio_guard
  import spg_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int PRIO_W   = 3,
  parameter int TASK_W   = 4,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SET_W-1:0]  reqSet,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [TASK_W-1:0] reqTask,
  input  logic              doneValid,
  input  logic [TASK_W-1:0] doneTask,
  output logic              grant,
  output logic              deny,
  output logic [PRIO_W-1:0] setPrio,
  output logic              busy
);

  spg_strobe_t       strobe;
  logic              accessOk;
  logic [SET_W-1:0]  sweepIdx;
  logic [TASK_W-1:0] sweepTask;

  spg_ctrl #(
    .NUM_SETS (NUM_SETS),
    .TASK_W   (TASK_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .doneValid (doneValid),
    .doneTask  (doneTask),
    .accessOk  (accessOk),
    .grant     (grant),
    .deny      (deny),
    .busy      (busy),
    .strobe    (strobe),
    .sweepIdx  (sweepIdx),
    .sweepTask (sweepTask)
  );

  spg_datapath #(
    .NUM_SETS (NUM_SETS),
    .PRIO_W   (PRIO_W),
    .TASK_W   (TASK_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqSet    (reqSet),
    .reqPrio   (reqPrio),
    .reqTask   (reqTask),
    .sweepIdx  (sweepIdx),
    .sweepTask (sweepTask),
    .setPrio   (setPrio),
    .accessOk  (accessOk)
  );

  // R8
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(grant || deny));

endmodule

// File: tb/set_prio_guard_test.sv
`timescale 1ns/1ps
module set_prio_guard_test;

  localparam int NSETS = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [5:0] reqSet = '0;
  logic [2:0] reqPrio = '0;
  logic [3:0] reqTask = '0;
  logic       doneValid = 1'b0;
  logic [3:0] doneTask = '0;
  logic       grant, deny, busy;
  logic [2:0] setPrio;

  always #2 clk = ~clk;  // 250 MHz

  set_prio_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSet(reqSet),
    .reqPrio(reqPrio), .reqTask(reqTask), .doneValid(doneValid),
    .doneTask(doneTask), .grant(grant), .deny(deny), .setPrio(setPrio),
    .busy(busy)
  );

  typedef struct packed {
    logic       g;
    logic       d;
    logic [2:0] p;
    logic       b;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  int    mPrio[NSETS];
  int    mOwner[NSETS];

  // Monitor: compares queued expectations one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({grant, deny, setPrio, busy} !== e) begin
          fails++;
          $display("FAIL %s: got grant=%0b deny=%0b setPrio=%0d busy=%0b, expected grant=%0b deny=%0b setPrio=%0d busy=%0b",
                   t, grant, deny, setPrio, busy, e.g, e.d, e.p, e.b);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic access(input int s, input int p, input int t, input string tag);
    exp_t e;
    bit   ok;
    @(negedge clk);
    reqValid = 1'b1; reqSet = 6'(s); reqPrio = 3'(p); reqTask = 4'(t);
    ok = (p >= mPrio[s]);
    e = '{g: ok, d: !ok, p: 3'(mPrio[s]), b: 1'b0};
    expQ.push_back(e); tagQ.push_back(tag);
    if (ok) begin
      mPrio[s] = p;
      mOwner[s] = t;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic probe(input int s, input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b0; reqSet = 6'(s);
    e = '{g: 1'b0, d: 1'b0, p: 3'(mPrio[s]), b: 1'b0};
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
  endtask

  // Completion with busy-length check; optionally injects a stalled access
  // and an ignored second completion during the sweep.
  task automatic complete(input int t, input bit intrude);
    exp_t e;
    int   cnt;
    @(negedge clk);
    reqValid = 1'b0; doneValid = 1'b1; doneTask = 4'(t); reqSet = 6'd0;
    e = '{g: 1'b0, d: 1'b0, p: 3'(mPrio[0]), b: 1'b0};
    expQ.push_back(e); tagQ.push_back("R7 busy low in pulse cycle");
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      reqValid = 1'b0; doneValid = 1'b0;
      if (intrude && cnt == 3) begin
        // R8: request that would win if idle; R9: completion for task 2
        reqValid = 1'b1; reqSet = 6'd0; reqPrio = 3'd7; reqTask = 4'd5;
        doneValid = 1'b1; doneTask = 4'd2;
        e = '{g: 1'b0, d: 1'b0, p: 3'(mPrio[0]), b: 1'b1};
        expQ.push_back(e); tagQ.push_back("R8 stalled request during sweep");
      end
      #1;
      if (busy) cnt++;
      else break;
    end
    checks++;
    if (cnt != NSETS) begin
      fails++;
      $display("FAIL R7: busy cycles got %0d expected %0d", cnt, NSETS);
    end
    for (int s = 0; s < NSETS; s++)
      if (mOwner[s] == t) mPrio[s] = 0;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NSETS; s++) begin
      mPrio[s] = 0;
      mOwner[s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of first, middle and last sets
    probe(0,  "R1 reset level set 0");
    probe(17, "R1 reset level set 17");
    probe(63, "R1 reset level set 63");

    // R2 R3: higher priority wins, level rises
    access(5, 3, 1, "R2 grant higher prio");
    probe(5, "R3 level raised set 5");
    // R2 R4: lower priority refused, nothing changes
    access(5, 2, 2, "R2 deny lower prio");
    probe(5, "R4 level unchanged after deny");
    // R5: equal priority, different owner
    access(5, 3, 4, "R5 grant equal prio new owner");
    probe(5, "R5 level kept on equal claim");

    access(9, 7, 1, "R2 grant top prio");
    access(9, 6, 3, "R4 deny below top");
    access(63, 2, 1, "R3 claim last set");
    access(0, 4, 2, "R3 claim first set");
    access(0, 0, 6, "R2 deny lowest prio on raised set");

    // R6: observation without request, mid-range and raised sets
    probe(9,  "R6 read set 9");
    probe(63, "R6 read set 63");

    // R7 R8 R9: release task 1 while injecting stalled traffic
    complete(1, 1'b1);
    probe(9,  "R7 released set 9");
    probe(63, "R7 released last set");
    probe(5,  "R5 old owner completion leaves set 5");
    probe(0,  "R9 ignored completion keeps set 0");

    // R5: new owner's completion releases set 5
    complete(4, 1'b0);
    probe(5, "R5 new owner completion releases set 5");

    // R7: last index owned by the completing task
    access(63, 5, 3, "R3 claim last set again");
    access(9, 1, 3, "R3 claim set 9 low");
    complete(3, 1'b0);
    probe(63, "R7 sweep reaches last index");
    probe(9,  "R7 sweep clears set 9");
    probe(0,  "R7 other owner untouched");

    // R7 then R2: task 2 releases set 0, lowest level may use it again
    complete(2, 1'b0);
    probe(0, "R7 first index released");
    access(0, 0, 6, "R2 grant lowest prio on free set");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule